// File: doc/BRIEF.md
# Clock Source Control Register with Safety Interlocks

This block is the software-visible control point of a clock generator. It stores a PLL enable flag, a flag that asks a downstream glitch-free switch to run the base clock from the PLL output instead of the oscillator, and three 8-bit PLL factors: a reference divider, a feedback multiplier and a range factor. It filters every write to the control flags through a small set of interlocks, so that software cannot reach a state in which the base clock is asked to follow a PLL that is stopped.

Reads always return the values that are stored. Separate outputs carry the effective divider and multiplier, with a stored zero mapped to one, together with a PLL-active signal and the select request. A range factor of zero stops the PLL whatever the enable flag holds, and forces the base clock back to the oscillator. When a write to the control flags is refused in whole or in part, a flag pulses for one cycle.

Top module: `clkgen_ctrl`

## Requirements
- R1: The port has four 8-bit locations. Address 0 holds control, with bit 0 the PLL enable and bit 1 the PLL select; bits 7:2 are ignored on write and read as 0. Address 1 holds the reference divider, address 2 the feedback multiplier and address 3 the range factor. `rd_data` shows the stored value at `addr` in the same cycle, with no register stage.
- R2: After reset the enable flag, the select flag and all three factors are 0, `pll_active` and `sel_pll_req` are 0, and `wr_rej` is 0.
- R3: `div_eff` equals the stored divider and `mul_eff` the stored multiplier, except that a stored 0 appears as 1 on these outputs.
- R4: `pll_active` is 1 exactly when the enable flag is 1 and the stored range factor is nonzero.
- R5: A control write that sets the select flag is refused (select stays 0) unless the enable flag is already 1 and the range factor is nonzero.
- R6: A control write that clears the enable flag while the select flag is 1 is refused, and the enable flag stays 1.
- R7: A control write that would change both the enable flag and the select flag leaves both unchanged.
- R8: Writing 0 to the range factor clears the select flag in the same cycle. This clearing does not count as a refusal.
- R9: `wr_rej` is 1 for exactly the cycle after a control write in which any requested flag change was refused, and is 0 otherwise.
- R10: A control write that breaks none of the rules of R5 to R7 takes effect in full, and writes to the factor locations never change the enable flag.
- R11: `sel_pll_req` equals the stored select flag and is never 1 while `pll_active` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for one cycle |
| addr | input | 2 | Location to write or read |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Stored value at `addr` |
| div_eff | output | 8 | Effective reference divider |
| mul_eff | output | 8 | Effective feedback multiplier |
| rng_val | output | 8 | Stored range factor |
| pll_active | output | 1 | PLL running (enabled with a nonzero range) |
| sel_pll_req | output | 1 | Request to run the base clock from the PLL |
| wr_rej | output | 1 | Pulse: the last control write was refused in part or in whole |

## Verification
The bench targets the transitions that the interlocks guard. It tries to set select with the PLL off or with the range at zero. A design that gets this wrong raises `sel_pll_req` while `pll_active` is low. It tries to clear enable while select is set; a faulty design lets the PLL stop under a live selection. It writes both flags at once; a design that applies half of such a write ends up in an illegal or unintended state. It zeroes the range factor while select is set, and a design that fails to force the oscillator keeps the request asserted. Random writes with small, zero-biased factor values exercise the zero-to-one mapping and check the refusal pulse against a model after every write.

// File: rtl/clkgen_ctrl_pkg.sv
package clkgen_ctrl_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] LOC_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] LOC_DIV  = 2'd1;
    localparam logic [ADDR_W-1:0] LOC_MUL  = 2'd2;
    localparam logic [ADDR_W-1:0] LOC_RNG  = 2'd3;

    localparam int BIT_EN  = 0;
    localparam int BIT_SEL = 1;

    typedef struct packed {
        logic              en;
        logic              sel;
        logic [DATA_W-1:0] div;
        logic [DATA_W-1:0] mul;
        logic [DATA_W-1:0] rng;
        logic              rej;
    } ctrl_state_t;
endpackage

// File: rtl/clkgen_interlock.sv
module clkgen_interlock (
    input  logic cur_en,
    input  logic cur_sel,
    input  logic rng_zero,
    input  logic req_en,
    input  logic req_sel,
    output logic nxt_en,
    output logic nxt_sel,
    output logic refused
);
    logic chg_en;
    logic chg_sel;

    always_comb begin
        chg_en  = (req_en != cur_en);
        chg_sel = (req_sel != cur_sel);
        nxt_en  = cur_en;
        nxt_sel = cur_sel;
        refused = 1'b0;
        if (chg_en && chg_sel) begin
            refused = 1'b1;
        end else if (chg_sel) begin
            if (req_sel && (!cur_en || rng_zero)) begin
                refused = 1'b1;
            end else begin
                nxt_sel = req_sel;
            end
        end else if (chg_en) begin
            if (!req_en && cur_sel) begin
                refused = 1'b1;
            end else begin
                nxt_en = req_en;
            end
        end
    end
endmodule

// File: rtl/clkgen_factor_map.sv
module clkgen_factor_map #(
    parameter int W = 8
) (
    input  logic [W-1:0] raw,
    output logic [W-1:0] eff
);
    localparam logic [W-1:0] ONE = W'(1);

    always_comb begin
        eff = (raw == '0) ? ONE : raw;
    end
endmodule

// File: rtl/clkgen_ctrl.sv
module clkgen_ctrl
    import clkgen_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] div_eff,
    output logic [DATA_W-1:0] mul_eff,
    output logic [DATA_W-1:0] rng_val,
    output logic              pll_active,
    output logic              sel_pll_req,
    output logic              wr_rej
);
    localparam int NFAC = 2;

    ctrl_state_t st_d, st_q;

    logic il_en, il_sel, il_ref;

    clkgen_interlock u_lock (
        .cur_en  (st_q.en),
        .cur_sel (st_q.sel),
        .rng_zero(st_q.rng == '0),
        .req_en  (wr_data[BIT_EN]),
        .req_sel (wr_data[BIT_SEL]),
        .nxt_en  (il_en),
        .nxt_sel (il_sel),
        .refused (il_ref)
    );

    logic [DATA_W-1:0] fac_raw [NFAC];
    logic [DATA_W-1:0] fac_eff [NFAC];

    assign fac_raw[0] = st_q.div;
    assign fac_raw[1] = st_q.mul;

    generate
        for (genvar g = 0; g < NFAC; g++) begin : g_map
            clkgen_factor_map #(.W(DATA_W)) u_map (
                .raw(fac_raw[g]),
                .eff(fac_eff[g])
            );
        end
    endgenerate

    always_comb begin
        st_d     = st_q;
        st_d.rej = 1'b0;
        if (wr_en) begin
            unique case (addr)
                LOC_CTRL: begin
                    st_d.en  = il_en;
                    st_d.sel = il_sel;
                    st_d.rej = il_ref;
                end
                LOC_DIV: st_d.div = wr_data;
                LOC_MUL: st_d.mul = wr_data;
                LOC_RNG: begin
                    st_d.rng = wr_data;
                    if (wr_data == '0) st_d.sel = 1'b0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (addr)
            LOC_CTRL: begin
                rd_data          = '0;
                rd_data[BIT_EN]  = st_q.en;
                rd_data[BIT_SEL] = st_q.sel;
            end
            LOC_DIV: rd_data = st_q.div;
            LOC_MUL: rd_data = st_q.mul;
            default: rd_data = st_q.rng;
        endcase
    end

    assign div_eff     = fac_eff[0];
    assign mul_eff     = fac_eff[1];
    assign rng_val     = st_q.rng;
    assign pll_active  = st_q.en && (st_q.rng != '0);
    assign sel_pll_req = st_q.sel;
    assign wr_rej      = st_q.rej;
endmodule

// File: rtl/clkgen_ctrl_chk.sv
module clkgen_ctrl_chk
    import clkgen_ctrl_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] div_eff,
    input logic [DATA_W-1:0] mul_eff,
    input logic [DATA_W-1:0] rng_val,
    input logic              pll_active,
    input logic              sel_pll_req,
    input logic              wr_rej,
    input ctrl_state_t       st_q
);
    assert_div_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        div_eff != '0 && mul_eff != '0);

    assert_rng_zero_stops_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rng_val == '0) |-> !pll_active);

    assert_sel_needs_pll_R11: assert property (@(posedge clk) disable iff (!rst_n)
        sel_pll_req |-> pll_active);

    assert_en_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == LOC_CTRL && !wr_data[BIT_EN] && wr_data[BIT_SEL] == st_q.sel && st_q.sel)
        |=> st_q.en);

    assert_both_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == LOC_CTRL && wr_data[BIT_EN] != st_q.en && wr_data[BIT_SEL] != st_q.sel)
        |=> ($stable(st_q.en) && $stable(st_q.sel)));

    assert_rej_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_rej |-> ($past(wr_en) && $past(addr) == LOC_CTRL));

    assert_rng_zero_desel_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == LOC_RNG && wr_data == '0) |=> (!sel_pll_req && !wr_rej));
endmodule

bind clkgen_ctrl clkgen_ctrl_chk u_chk (.*);

// File: tb/sim_clkgen_ctrl.sv
module sim_clkgen_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] rd_data, div_eff, mul_eff, rng_val;
    logic       pll_active, sel_pll_req, wr_rej;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic       m_en, m_sel, m_rej;
    logic [7:0] m_div, m_mul, m_rng;

    always #5 clk = ~clk;

    clkgen_ctrl u0 (.*);

    function automatic logic [7:0] eff(input logic [7:0] v);
        return (v == 8'd0) ? 8'd1 : v;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // model of R5-R10
    task automatic model_write(input logic [1:0] a, input logic [7:0] d);
        logic ce, cs;
        m_rej = 1'b0;
        case (a)
            2'd0: begin
                ce = d[0] != m_en;
                cs = d[1] != m_sel;
                if (ce && cs) m_rej = 1'b1;
                else if (cs) begin
                    if (d[1] && (!m_en || m_rng == 0)) m_rej = 1'b1;
                    else m_sel = d[1];
                end else if (ce) begin
                    if (!d[0] && m_sel) m_rej = 1'b1;
                    else m_en = d[0];
                end
            end
            2'd1: m_div = d;
            2'd2: m_mul = d;
            default: begin
                m_rng = d;
                if (d == 0) m_sel = 1'b0;
            end
        endcase
    endtask

    task automatic check_outputs();
        chk(wr_rej == m_rej, "R9 wr_rej", wr_rej, m_rej);
        chk(pll_active == (m_en && m_rng != 0), "R4 pll_active", pll_active, m_en && m_rng != 0);
        chk(sel_pll_req == m_sel, "R11 sel_pll_req", sel_pll_req, m_sel);
        chk(div_eff == eff(m_div), "R3 div_eff", div_eff, eff(m_div));
        chk(mul_eff == eff(m_mul), "R3 mul_eff", mul_eff, eff(m_mul));
        chk(rng_val == m_rng, "R1 rng_val", rng_val, m_rng);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        model_write(a, d);
        check_outputs();
        @(negedge clk);
        chk(wr_rej == 1'b0, "R9 pulse one cycle", wr_rej, 0);
    endtask

    task automatic read_all();
        for (int i = 0; i < 4; i++) begin
            logic [7:0] e;
            @(negedge clk);
            addr = 2'(i);
            #1;
            case (i)
                0: e = {6'd0, m_sel, m_en};
                1: e = m_div;
                2: e = m_mul;
                default: e = m_rng;
            endcase
            chk(rd_data == e, "R1 rd_data", rd_data, e);
        end
    endtask

    initial begin
        #1000000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        m_en = 0; m_sel = 0; m_rej = 0; m_div = 0; m_mul = 0; m_rng = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 reset state
        chk(pll_active == 0 && sel_pll_req == 0 && wr_rej == 0, "R2 status", {pll_active, sel_pll_req, wr_rej}, 0);
        check_outputs();
        read_all();
        // R5 select with PLL off
        wr(2'd0, 8'h02);
        chk(sel_pll_req == 0, "R5 select refused while off", sel_pll_req, 0);
        // R7 both at once
        wr(2'd0, 8'h03);
        chk(rd_data[1:0] == 2'b00, "R7 both unchanged", rd_data[1:0], 0);
        // R10 enable with range zero, then R5 select blocked by range 0
        wr(2'd0, 8'hFD);
        chk(pll_active == 0, "R4 enabled but range zero", pll_active, 0);
        wr(2'd0, 8'h03);
        chk(sel_pll_req == 0 && wr_rej == 0, "R5 range zero blocks select", sel_pll_req, 0);
        wr(2'd3, 8'h05);
        wr(2'd0, 8'h03);
        chk(sel_pll_req == 1, "R10 legal select", sel_pll_req, 1);
        // R6 clear enable while selected
        wr(2'd0, 8'h02);
        read_all();
        // R7 drop both
        wr(2'd0, 8'h00);
        // R8 range zero forces oscillator
        wr(2'd3, 8'h00);
        chk(sel_pll_req == 0, "R8 range zero clears select", sel_pll_req, 0);
        // R3 zero factors
        wr(2'd1, 8'h00);
        wr(2'd2, 8'h00);
        wr(2'd1, 8'h07);
        read_all();
        // random
        for (int k = 0; k < 400; k++) begin
            logic [1:0] a;
            logic [7:0] d;
            a = 2'($urandom % 4);
            if (a == 2'd0) d = 8'($urandom % 4);
            else d = ($urandom % 3 == 0) ? 8'd0 : 8'($urandom);
            wr(a, d);
            if (k % 25 == 0) read_all();
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule